// File: doc/BRIEF.md
# Byte-Stuffed Packet Framing Codec

This block carries a channelized packet stream over a plain 8-bit byte link, in both directions at once. The unstuffing path accepts raw bytes on a valid/ready sink. It removes four reserved marker values and emits packet beats that carry start-of-packet, end-of-packet and channel. The stuffing path does the reverse. It accepts packet beats and emits a byte stream with the framing markers and escape prefixes inserted. The byte side carries no packet signals of its own.

The reserved values sit in a contiguous range, 0x7A to 0x7D:

| Value | Meaning |
|-------|---------|
| 0x7A | opens a packet |
| 0x7B | flags the final data byte of a packet |
| 0x7C | announces a channel number |
| 0x7D | escapes the byte that follows |

An escaped byte is transmitted XORed with 0x20. Both interfaces use zero ready latency, and a beat or byte moves on any clock edge where valid and ready are both high. Channel numbers are one byte wide. A channel switch inside a packet travels as an inline channel marker. Upstream must hold each beat or byte stable while its ready is low.

Top module: `pkt_byte_codec`

## Requirements
- R1: In the unstuffer, an unescaped 0x7D is dropped. The following byte is taken as a literal value XORed with 0x20, even when that byte is itself a marker. An unescaped output beat never carries a value in 0x7A..0x7D.
- R2: In the unstuffer, an unescaped 0x7A is dropped, and the next data beat is emitted with start-of-packet high.
- R3: In the unstuffer, an unescaped 0x7B is dropped, and the next data beat is emitted with end-of-packet high. A one-byte packet has both flags high on the same beat.
- R4: In the unstuffer, an unescaped 0x7C is dropped. The next literal byte, escaped or not, becomes the channel shown on `dec_out_chan` and produces no beat. Markers that arrive in between keep their own meaning.
- R5: The unstuffer accepts every marker or channel-value byte in the cycle it is offered, whatever `dec_out_ready` is, and emits no beat for it. A data byte is accepted only together with its output beat.
- R6: For a beat with start-of-packet high, the stuffer emits 0x7C, then the channel (escaped if reserved), then 0x7A, and then the data.
- R7: For a beat with end-of-packet high, the stuffer emits 0x7B directly ahead of that beat's data byte or its escape prefix.
- R8: Inside an open packet, a beat whose channel differs from the previous beat's channel is preceded by 0x7C and the new channel, escaped if reserved.
- R9: The stuffer sends any data or channel byte in 0x7A..0x7D as 0x7D followed by the byte XORed with 0x20.
- R10: `enc_in_ready` is high only in the cycle when the beat's data byte leaves on a completed output handshake. While `enc_out_ready` is low, the output byte holds its value.
- R11: During and right after reset, both output valids are low, `enc_in_ready` is low and `dec_out_chan` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| dec_in_valid | input | 1 | raw byte offered to the unstuffer |
| dec_in_data | input | 8 | raw byte |
| dec_in_ready | output | 1 | unstuffer takes the byte |
| dec_out_valid | output | 1 | decoded beat valid |
| dec_out_data | output | 8 | decoded data byte |
| dec_out_sop | output | 1 | decoded beat opens a packet |
| dec_out_eop | output | 1 | decoded beat closes a packet |
| dec_out_chan | output | 8 | current decoded channel |
| dec_out_ready | input | 1 | downstream takes the decoded beat |
| enc_in_valid | input | 1 | packet beat offered to the stuffer |
| enc_in_data | input | 8 | beat data byte |
| enc_in_sop | input | 1 | beat opens a packet |
| enc_in_eop | input | 1 | beat closes a packet |
| enc_in_chan | input | 8 | beat channel |
| enc_in_ready | output | 1 | stuffer takes the beat |
| enc_out_valid | output | 1 | stuffed byte valid |
| enc_out_data | output | 8 | stuffed byte |
| enc_out_ready | input | 1 | downstream takes the stuffed byte |

## Verification
A stale escape or pending-flag register in the unstuffer shows at the ports on the very next data beat, as a wrong value, a wrong start or end flag, or a marker that leaks out as a beat. A wrong stage register in the stuffer shows at once as a skipped, repeated or misplaced byte in the output stream. It also shows as `enc_in_ready` rising on a marker byte. The sweep sends every byte value through both paths, with reserved channels and channel switches inside a packet, while the output ready stalls on an irregular pattern. Every byte and beat is compared in the cycle it is transferred.

// File: rtl/pbc_pkg.sv
package pbc_pkg;

    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;

    // reserved symbols; the range check in is_reserved relies on them being contiguous
    localparam byte_t SYM_SOP  = 8'h7A;
    localparam byte_t SYM_EOP  = 8'h7B;
    localparam byte_t SYM_CHN  = 8'h7C;
    localparam byte_t SYM_ESC  = 8'h7D;
    localparam byte_t ESC_FLIP = 8'h20;

    // emission stages of the stuffer, in wire order
    localparam int N_STAGE = 7;
    localparam int STG_W   = $clog2(N_STAGE);
    typedef logic [STG_W-1:0] stage_t;
    localparam stage_t STG_CMARK = 3'd0;
    localparam stage_t STG_CESC  = 3'd1;
    localparam stage_t STG_CVAL  = 3'd2;
    localparam stage_t STG_SOPM  = 3'd3;
    localparam stage_t STG_EOPM  = 3'd4;
    localparam stage_t STG_DESC  = 3'd5;
    localparam stage_t STG_DATA  = 3'd6;

    typedef struct packed {
        byte_t data;
        logic  sop;
        logic  eop;
        byte_t chan;
    } beat_t;

    function automatic logic is_reserved(byte_t b);
        return (b >= SYM_SOP) && (b <= SYM_ESC);
    endfunction

    function automatic byte_t flip(byte_t b);
        return b ^ ESC_FLIP;
    endfunction

endpackage

// File: rtl/pbc_unstuff.sv
module pbc_unstuff
    import pbc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  byte_t in_data,
    output logic  in_ready,
    output logic  out_valid,
    output beat_t out_beat,
    input  logic  out_ready
);

    logic  esc_q, sop_q, eop_q, chn_q;
    byte_t chan_q;

    logic  literal, take_chan, is_beat, fire;
    byte_t value;

    always_comb begin
        literal   = esc_q || !is_reserved(in_data);
        take_chan = literal && chn_q;
        is_beat   = literal && !chn_q;
        value     = esc_q ? flip(in_data) : in_data;
        out_valid = in_valid && is_beat && !rst;
        in_ready  = !rst && (is_beat ? out_ready : 1'b1);
        fire      = in_valid && in_ready;
        out_beat  = '{data: value, sop: sop_q, eop: eop_q, chan: chan_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            esc_q  <= 1'b0;
            sop_q  <= 1'b0;
            eop_q  <= 1'b0;
            chn_q  <= 1'b0;
            chan_q <= '0;
        end else if (fire) begin
            if (is_beat) begin
                esc_q <= 1'b0;
                sop_q <= 1'b0;
                eop_q <= 1'b0;
            end else if (take_chan) begin
                chan_q <= value;
                chn_q  <= 1'b0;
                esc_q  <= 1'b0;
            end else begin
                unique case (in_data)
                    SYM_ESC: esc_q <= 1'b1;
                    SYM_SOP: sop_q <= 1'b1;
                    SYM_EOP: eop_q <= 1'b1;
                    default: chn_q <= 1'b1;
                endcase
            end
        end
    end

    // R1: an unescaped beat can never carry a reserved value
    p_plain_beat_r1: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !esc_q) |-> !is_reserved(out_beat.data));

    // R5: a marker is swallowed at once and never becomes a beat
    p_marker_swallowed_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !esc_q && is_reserved(in_data)) |-> (in_ready && !out_valid));

endmodule

// File: rtl/pbc_stuff.sv
module pbc_stuff
    import pbc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  beat_t in_beat,
    output logic  in_ready,
    output logic  out_valid,
    output byte_t out_data,
    input  logic  out_ready
);

    stage_t ph_q, cur;
    byte_t  last_ch_q;
    logic   in_pkt_q;

    logic               need_ch, hs;
    logic [N_STAGE-1:0] app;

    always_comb begin
        need_ch        = in_beat.sop || (in_pkt_q && (in_beat.chan != last_ch_q));
        app            = '0;
        app[STG_CMARK] = need_ch;
        app[STG_CESC]  = need_ch && is_reserved(in_beat.chan);
        app[STG_CVAL]  = need_ch;
        app[STG_SOPM]  = in_beat.sop;
        app[STG_EOPM]  = in_beat.eop;
        app[STG_DESC]  = is_reserved(in_beat.data);
        app[STG_DATA]  = 1'b1;
        // first applicable stage at or after the current phase
        cur = STG_DATA;
        for (int s = N_STAGE - 1; s >= 0; s--) begin
            if ((stage_t'(s) >= ph_q) && app[s]) cur = stage_t'(s);
        end
    end

    always_comb begin
        unique case (cur)
            STG_CMARK: out_data = SYM_CHN;
            STG_CESC:  out_data = SYM_ESC;
            STG_CVAL:  out_data = is_reserved(in_beat.chan) ? flip(in_beat.chan) : in_beat.chan;
            STG_SOPM:  out_data = SYM_SOP;
            STG_EOPM:  out_data = SYM_EOP;
            STG_DESC:  out_data = SYM_ESC;
            default:   out_data = is_reserved(in_beat.data) ? flip(in_beat.data) : in_beat.data;
        endcase
        out_valid = in_valid && !rst;
        hs        = out_valid && out_ready;
        in_ready  = hs && (cur == STG_DATA);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q      <= STG_CMARK;
            last_ch_q <= '0;
            in_pkt_q  <= 1'b0;
        end else if (hs) begin
            if (cur == STG_DATA) begin
                ph_q      <= STG_CMARK;
                last_ch_q <= in_beat.chan;
                if (in_beat.eop)      in_pkt_q <= 1'b0;
                else if (in_beat.sop) in_pkt_q <= 1'b1;
            end else begin
                ph_q <= stage_t'(cur + stage_t'(1));
            end
        end
    end

    // R10: the beat is taken only with a completed byte handshake
    p_ready_on_send_r10: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> (out_valid && out_ready));

    // R10: a stalled byte keeps its value
    p_stall_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R9: the byte after an escape prefix is never reserved
    p_escape_follow_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(out_valid && out_ready && (out_data == SYM_ESC)) && out_valid)
            |-> !is_reserved(out_data));

endmodule

// File: rtl/pkt_byte_codec.sv
module pkt_byte_codec
    import pbc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       dec_in_valid,
    input  logic [7:0] dec_in_data,
    output logic       dec_in_ready,
    output logic       dec_out_valid,
    output logic [7:0] dec_out_data,
    output logic       dec_out_sop,
    output logic       dec_out_eop,
    output logic [7:0] dec_out_chan,
    input  logic       dec_out_ready,
    input  logic       enc_in_valid,
    input  logic [7:0] enc_in_data,
    input  logic       enc_in_sop,
    input  logic       enc_in_eop,
    input  logic [7:0] enc_in_chan,
    output logic       enc_in_ready,
    output logic       enc_out_valid,
    output logic [7:0] enc_out_data,
    input  logic       enc_out_ready
);

    beat_t dec_beat, enc_beat;

    assign enc_beat = '{data: enc_in_data, sop: enc_in_sop, eop: enc_in_eop, chan: enc_in_chan};

    pbc_unstuff u_unstuff (
        .clk      (clk),
        .rst      (rst),
        .in_valid (dec_in_valid),
        .in_data  (dec_in_data),
        .in_ready (dec_in_ready),
        .out_valid(dec_out_valid),
        .out_beat (dec_beat),
        .out_ready(dec_out_ready)
    );

    assign dec_out_data = dec_beat.data;
    assign dec_out_sop  = dec_beat.sop;
    assign dec_out_eop  = dec_beat.eop;
    assign dec_out_chan = dec_beat.chan;

    pbc_stuff u_stuff (
        .clk      (clk),
        .rst      (rst),
        .in_valid (enc_in_valid),
        .in_beat  (enc_beat),
        .in_ready (enc_in_ready),
        .out_valid(enc_out_valid),
        .out_data (enc_out_data),
        .out_ready(enc_out_ready)
    );

endmodule

// File: tb/sim_pkt_byte_codec.sv
module sim_pkt_byte_codec;

    localparam int CLK_PERIOD = 10;
    localparam int MAXN       = 2048;
    localparam int WATCHDOG   = 50000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dec_in_valid = 1'b0;
    logic [7:0] dec_in_data = '0;
    logic       dec_in_ready;
    logic       dec_out_valid;
    logic [7:0] dec_out_data;
    logic       dec_out_sop, dec_out_eop;
    logic [7:0] dec_out_chan;
    logic       dec_out_ready = 1'b0;
    logic       enc_in_valid = 1'b0;
    logic [7:0] enc_in_data = '0;
    logic       enc_in_sop = 1'b0, enc_in_eop = 1'b0;
    logic [7:0] enc_in_chan = '0;
    logic       enc_in_ready;
    logic       enc_out_valid;
    logic [7:0] enc_out_data;
    logic       enc_out_ready = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pkt_byte_codec u0 (.*);

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always @(posedge clk) cyc++;

    // packet beats
    logic [7:0] bd [MAXN];
    bit         bs [MAXN];
    bit         be [MAXN];
    logic [7:0] bc [MAXN];
    int nb = 0;
    // stuffed byte stream: value, data-byte flag, requirement tag
    logic [7:0] xb [MAXN];
    bit         xk [MAXN];
    string      xt [MAXN];
    int nx = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit rsv(input logic [7:0] b);
        return (b >= 8'h7A) && (b <= 8'h7D);
    endfunction

    task automatic add_beat(input logic [7:0] d, input bit s, input bit e, input logic [7:0] c);
        bd[nb] = d; bs[nb] = s; be[nb] = e; bc[nb] = c; nb++;
    endtask

    task automatic push(input logic [7:0] b, input bit k, input string t);
        xb[nx] = b; xk[nx] = k; xt[nx] = t; nx++;
    endtask

    task automatic push_esc(input logic [7:0] b, input bit k, input string t);
        if (rsv(b)) begin
            push(8'h7D, 1'b0, "R9");
            push(b ^ 8'h20, k, "R9");
        end else begin
            push(b, k, t);
        end
    endtask

    // reference stuffing of beat list, straight from the requirements
    task automatic build_stream();
        bit         inp = 1'b0;
        logic [7:0] lc = 8'h00;
        for (int i = 0; i < nb; i++) begin
            if (bs[i] || (inp && bc[i] != lc)) begin
                push(8'h7C, 1'b0, bs[i] ? "R6" : "R8");
                push_esc(bc[i], 1'b0, bs[i] ? "R6" : "R8");
            end
            if (bs[i]) push(8'h7A, 1'b0, "R6");
            if (be[i]) push(8'h7B, 1'b0, "R7");
            push_esc(bd[i], 1'b1, "R9");
            lc = bc[i];
            if (be[i]) inp = 1'b0;
            else if (bs[i]) inp = 1'b1;
        end
    endtask

    function automatic bit rdy_pat(input int c);
        return (c % 7 != 2) && (c % 11 != 5);
    endfunction

    task automatic run_stuffer();
        int i = 0;
        int k = 0;
        bit stalled = 1'b0;
        logic [7:0] held = '0;
        while (i < nb) begin
            @(negedge clk);
            enc_in_valid  = 1'b1;
            enc_in_data   = bd[i];
            enc_in_sop    = bs[i];
            enc_in_eop    = be[i];
            enc_in_chan   = bc[i];
            enc_out_ready = rdy_pat(cyc);
            #(CLK_PERIOD / 4);
            if (stalled) chk(enc_out_data == held, "R10 hold", enc_out_data, held);
            chk(!enc_in_ready || (enc_out_valid && enc_out_ready), "R10 ready", enc_in_ready, 0);
            if (enc_out_valid && enc_out_ready) begin
                chk(enc_out_data == xb[k], xt[k], enc_out_data, xb[k]);
                chk(enc_in_ready == xk[k], "R10 accept", enc_in_ready, xk[k]);
                k++;
            end
            stalled = enc_out_valid && !enc_out_ready;
            held    = enc_out_data;
            if (enc_in_ready) i++;
        end
        @(negedge clk);
        enc_in_valid = 1'b0;
        chk(k == nx, "R6 count", k, nx);
    endtask

    task automatic run_unstuffer();
        int j = 0;
        int m = 0;
        while (j < nx) begin
            @(negedge clk);
            dec_in_valid  = 1'b1;
            dec_in_data   = xb[j];
            dec_out_ready = rdy_pat(cyc + 3);
            #(CLK_PERIOD / 4);
            if (!xk[j]) begin
                chk(dec_in_ready && !dec_out_valid, "R5 marker", {dec_in_ready, dec_out_valid}, 2);
                j++;
            end else begin
                chk(dec_out_valid, "R1 valid", dec_out_valid, 1);
                chk(dec_in_ready == dec_out_ready, "R5 ready", dec_in_ready, dec_out_ready);
                if (dec_out_valid && dec_out_ready) begin
                    chk(dec_out_data == bd[m], "R1 data", dec_out_data, bd[m]);
                    chk(dec_out_sop == bs[m], "R2 sop", dec_out_sop, bs[m]);
                    chk(dec_out_eop == be[m], "R3 eop", dec_out_eop, be[m]);
                    chk(dec_out_chan == bc[m], "R4 chan", dec_out_chan, bc[m]);
                    m++;
                end
                if (dec_in_ready) j++;
            end
        end
        @(negedge clk);
        dec_in_valid = 1'b0;
        chk(m == nb, "R1 count", m, nb);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #(CLK_PERIOD / 4);
        // R11 during reset
        chk(!dec_out_valid && !enc_out_valid && !enc_in_ready, "R11 valid", {dec_out_valid, enc_out_valid}, 0);
        chk(dec_out_chan == 8'h00, "R11 chan", dec_out_chan, 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #(CLK_PERIOD / 4);
        chk(!dec_out_valid && !enc_out_valid && !enc_in_ready && dec_out_chan == 8'h00,
            "R11 idle", {dec_out_valid, enc_out_valid, enc_in_ready}, 0);

        // R3 single-byte packet with reserved payload
        add_beat(8'h7A, 1'b1, 1'b1, 8'h01);
        // full byte sweep, reserved channel, R8 switches mid-packet
        for (int v = 0; v < 256; v++)
            add_beat(8'(v), v == 0, v == 255, (v < 100) ? 8'h7B : (v < 200) ? 8'h7D : 8'h05);
        add_beat(8'h7C, 1'b1, 1'b0, 8'h10);
        add_beat(8'h7D, 1'b0, 1'b1, 8'h10);
        build_stream();
        run_stuffer();

        // directed unstuffer cases appended after the swept stream
        // R4: escaped channel value 0x7B
        push(8'h7C, 0, "R4"); push(8'h7D, 0, "R4"); push(8'h5B, 0, "R4");
        push(8'h7A, 0, "R2"); push(8'h7B, 0, "R3"); push(8'h41, 1, "R1");
        add_beat(8'h41, 1'b1, 1'b1, 8'h7B);
        // R4: start marker between channel marker and its value
        push(8'h7C, 0, "R4"); push(8'h7A, 0, "R2"); push(8'h03, 0, "R4");
        push(8'h44, 1, "R1"); push(8'h7B, 0, "R3"); push(8'h45, 1, "R1");
        add_beat(8'h44, 1'b1, 1'b0, 8'h03);
        add_beat(8'h45, 1'b0, 1'b1, 8'h03);
        // R1: escaped payload 0x7A, then an escaped escape
        push(8'h7C, 0, "R4"); push(8'h01, 0, "R4"); push(8'h7A, 0, "R2");
        push(8'h7D, 0, "R1"); push(8'h5A, 1, "R1");
        push(8'h7B, 0, "R3"); push(8'h7D, 0, "R1"); push(8'h5D, 1, "R1");
        add_beat(8'h7A, 1'b1, 1'b0, 8'h01);
        add_beat(8'h7D, 1'b0, 1'b1, 8'h01);
        run_unstuffer();

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog R10 actual=%0d expected=%0d", WATCHDOG, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule